// File: doc/BRIEF.md
# Shifted Template Least-Squares Matcher

The block classifies one stored test vector against a runtime-selected number of reference templates. For each template it slides the template over eleven positions around the aligned position. At each position it sums the squared sample differences between the vector and the shifted template. Template positions that fall outside the vector count as zero. It then reports the template and the shift with the smallest error, together with that error.

Both operands sit in external synchronous-read memories with one cycle of read latency. The block drives read enables and addresses and handles one sample per clock. A start pulse launches a search. A one-cycle done pulse marks the moment the result outputs become valid, and those outputs then hold until the next accepted start.

Top module: `template_matcher`

## Requirements
- R1: The error for one pair is the sum over all 70 vector positions of the squared difference between the 16-bit signed vector sample and the 16-bit signed template sample. It is reported as a 41-bit unsigned value that never wraps, even with full-scale samples of opposite sign.
- R2: For shift s (0 to 10), vector position i is compared with template sample j = i + 5 - s, so shift 5 means no offset. When j lies outside 0..69, the template value used is zero.
- R3: Templates are visited in the outer loop and shifts in the inner loop. The reported result is the pair with the minimum error. On equal errors the earlier pair in that order is kept, meaning the lower template index and then the lower shift.
- R4: A start pulse samples the template count, sets the held minimum error to all ones and sets the held template and shift to zero, before the search begins.
- R5: done is high for exactly one cycle. With N templates, it is high in the cycle that follows the N*770+2-th rising edge after the edge that sampled start.
- R6: Once done has pulsed, bestTpl, bestShift and bestErr do not change until the next accepted start, whatever the memories then return.
- R7: A start pulse that arrives while a search is running is ignored, and the running search completes with its original count.
- R8: A template count of zero produces done two cycles after start, with bestErr all ones and bestTpl and bestShift zero.
- R9: The vector address is the position i. The template address is template index times 70 plus j. tplRdEn is never asserted for an out-of-range j, and no template address at or beyond count*70 is read.
- R10: After reset, done is low, bestErr is all ones, and bestTpl and bestShift are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Search launch pulse |
| tplCount | input | 13 | Number of templates to search, sampled at start |
| vecRdEn | output | 1 | Test-vector memory read enable |
| vecAddr | output | 7 | Test-vector sample address |
| vecRdData | input | 16 | Test-vector read data, one cycle after the address |
| tplRdEn | output | 1 | Template memory read enable |
| tplAddr | output | 19 | Template memory address (index*70 + sample) |
| tplRdData | input | 16 | Template read data, one cycle after the address |
| done | output | 1 | One-cycle completion pulse |
| bestTpl | output | 12 | Index of the best template |
| bestShift | output | 4 | Best shift, 5 meaning no offset |
| bestErr | output | 41 | Minimum summed squared error |

## Verification
Random vectors with one template planted as a noisy copy of the vector at a chosen shift, including the extreme shifts 0 and 10 and the first and last template. These separate a correct shift direction, correct edge zeroing and correct template addressing from near misses. All-zero memories give equal errors everywhere, which exposes the tie rule. Full-scale opposite-sign samples expose accumulator truncation. A zero count and a start issued mid-search check the control corner cases. A read-data model that returns a poison value whenever tplRdEn is low reveals any reliance on unrequested template data.

// File: rtl/tmatch_pkg.sv
package tmatch_pkg;
  // Strobes passed from the control to the datapath with each issued read.
  typedef struct packed {
    logic issue;    // a sample pair is being read this cycle
    logic inRange;  // template position lies inside the vector
    logic first;    // first sample of a template/shift pair
    logic last;     // last sample of a template/shift pair
    logic clear;    // search accepted: reset the held minimum
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/tmatch_ctrl.sv
module tmatch_ctrl
  import tmatch_pkg::*;
#(
  parameter int VEC_LEN    = 70,
  parameter int NUM_SHIFTS = 11,
  parameter int MAX_TPL    = 4096,
  localparam int IDX_W     = $clog2(VEC_LEN),
  localparam int SHIFT_W   = $clog2(NUM_SHIFTS),
  localparam int TPL_W     = $clog2(MAX_TPL),
  localparam int CNT_W     = $clog2(MAX_TPL + 1),
  localparam int TADDR_W   = $clog2(MAX_TPL * VEC_LEN)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CNT_W-1:0]   tplCount,
  output logic               vecRdEn,
  output logic [IDX_W-1:0]   vecAddr,
  output logic               tplRdEn,
  output logic [TADDR_W-1:0] tplAddr,
  output logic               done,
  output logic               busy,
  output strobe_t            stb,
  output logic [TPL_W-1:0]   curTpl,
  output logic [SHIFT_W-1:0] curShift
);
  localparam int CENTER = NUM_SHIFTS / 2;
  localparam int J_W    = IDX_W + 2;

  ctrl_state_e        stateQ;
  logic [CNT_W-1:0]   countQ;
  logic [TPL_W-1:0]   tplQ;
  logic [SHIFT_W-1:0] shiftQ;
  logic [IDX_W-1:0]   idxQ;
  logic [TADDR_W-1:0] tplBaseQ;
  logic               drainQ;
  logic               doneQ;

  logic               accept, running, idxLast, shiftLast, tplLast, inRange;
  logic signed [J_W-1:0] jPos;

  assign accept    = start && (stateQ == ST_IDLE);
  assign running   = (stateQ == ST_RUN);
  assign idxLast   = (idxQ == IDX_W'(VEC_LEN - 1));
  assign shiftLast = (shiftQ == SHIFT_W'(NUM_SHIFTS - 1));
  assign tplLast   = (CNT_W'(tplQ) == countQ - CNT_W'(1));

  // Template sample paired with vector position idxQ at the current shift.
  always_comb begin
    jPos    = signed'(J_W'(idxQ)) + signed'(J_W'(CENTER)) - signed'(J_W'(shiftQ));
    inRange = !jPos[J_W-1] && (jPos[J_W-2:0] < (J_W-1)'(VEC_LEN));
  end

  assign vecRdEn  = running;
  assign vecAddr  = idxQ;
  assign tplRdEn  = running && inRange;
  assign tplAddr  = inRange ? tplBaseQ + TADDR_W'(jPos[J_W-2:0]) : tplBaseQ;
  assign done     = doneQ;
  assign busy     = (stateQ != ST_IDLE);
  assign curTpl   = tplQ;
  assign curShift = shiftQ;

  always_comb begin
    stb.issue   = running;
    stb.inRange = inRange;
    stb.first   = (idxQ == '0);
    stb.last    = idxLast;
    stb.clear   = accept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      countQ   <= '0;
      tplQ     <= '0;
      shiftQ   <= '0;
      idxQ     <= '0;
      tplBaseQ <= '0;
      drainQ   <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (stateQ)
        ST_IDLE: begin
          if (accept) begin
            countQ   <= tplCount;
            tplQ     <= '0;
            shiftQ   <= '0;
            idxQ     <= '0;
            tplBaseQ <= '0;
            drainQ   <= 1'b0;
            stateQ   <= (tplCount == '0) ? ST_DRAIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (!idxLast) begin
            idxQ <= idxQ + IDX_W'(1);
          end else begin
            idxQ <= '0;
            if (!shiftLast) begin
              shiftQ <= shiftQ + SHIFT_W'(1);
            end else begin
              shiftQ <= '0;
              if (tplLast) begin
                stateQ <= ST_DRAIN;
              end else begin
                tplQ     <= tplQ + TPL_W'(1);
                tplBaseQ <= tplBaseQ + TADDR_W'(VEC_LEN);
              end
            end
          end
        end
        ST_DRAIN: begin
          // Two cycles: read-data stage then compare stage.
          drainQ <= ~drainQ;
          if (drainQ) begin
            doneQ  <= 1'b1;
            stateQ <= ST_IDLE;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R2: loop counters stay inside their ranges while reading
  p_counter_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (shiftQ < SHIFT_W'(NUM_SHIFTS)) && (idxQ < IDX_W'(VEC_LEN)));

  // R9: template reads only alongside vector reads, and only below count
  p_tpl_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    tplRdEn |-> vecRdEn && (CNT_W'(tplQ) < countQ));

  // R7: a start during a search leaves the latched count untouched
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(countQ));
endmodule

// File: rtl/tmatch_dp.sv
module tmatch_dp
  import tmatch_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int VEC_LEN    = 70,
  parameter int NUM_SHIFTS = 11,
  parameter int MAX_TPL    = 4096,
  localparam int SHIFT_W   = $clog2(NUM_SHIFTS),
  localparam int TPL_W     = $clog2(MAX_TPL),
  localparam int DIFF_W    = SAMPLE_W + 1,
  localparam int SQ_W      = 2 * DIFF_W,
  localparam int ACC_W     = SQ_W + $clog2(VEC_LEN)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [TPL_W-1:0]    curTpl,
  input  logic [SHIFT_W-1:0]  curShift,
  input  logic [SAMPLE_W-1:0] vecRdData,
  input  logic [SAMPLE_W-1:0] tplRdData,
  output logic [TPL_W-1:0]    bestTpl,
  output logic [SHIFT_W-1:0]  bestShift,
  output logic [ACC_W-1:0]    bestErr
);
  // Stage 1: aligned with memory read data.
  strobe_t            s1Q;
  logic [TPL_W-1:0]   s1TplQ;
  logic [SHIFT_W-1:0] s1ShiftQ;
  logic [ACC_W-1:0]   accQ;

  // Stage 2: one finished pair error, compared against the held minimum.
  logic               errValidQ;
  logic [ACC_W-1:0]   errQ;
  logic [TPL_W-1:0]   errTplQ;
  logic [SHIFT_W-1:0] errShiftQ;

  logic signed [SAMPLE_W-1:0] tplVal;
  logic signed [DIFF_W-1:0]   diff;
  logic signed [SQ_W-1:0]     sqS;
  logic [ACC_W-1:0]           accSum;

  always_comb begin
    tplVal = s1Q.inRange ? signed'(tplRdData) : '0;
    diff   = signed'(DIFF_W'(signed'(vecRdData))) - signed'(DIFF_W'(tplVal));
    sqS    = diff * diff;
    accSum = (s1Q.first ? '0 : accQ) + ACC_W'(unsigned'(sqS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Q       <= '0;
      s1TplQ    <= '0;
      s1ShiftQ  <= '0;
      accQ      <= '0;
      errValidQ <= 1'b0;
      errQ      <= '0;
      errTplQ   <= '0;
      errShiftQ <= '0;
      bestTpl   <= '0;
      bestShift <= '0;
      bestErr   <= '1;
    end else begin
      s1Q       <= stb;
      s1TplQ    <= curTpl;
      s1ShiftQ  <= curShift;
      errValidQ <= s1Q.issue && s1Q.last;
      if (s1Q.issue) begin
        accQ <= accSum;
        if (s1Q.last) begin
          errQ      <= accSum;
          errTplQ   <= s1TplQ;
          errShiftQ <= s1ShiftQ;
        end
      end
      if (stb.clear) begin
        bestErr   <= '1;
        bestTpl   <= '0;
        bestShift <= '0;
      end else if (errValidQ && (errQ < bestErr)) begin
        // strict compare keeps the earlier pair on ties
        bestErr   <= errQ;
        bestTpl   <= errTplQ;
        bestShift <= errShiftQ;
      end
    end
  end

  // R1: the running sum never wraps
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    (s1Q.issue && !s1Q.first) |-> (accSum >= accQ));

  // R3: outside a clear, the held minimum only moves downward
  p_best_monotone_r3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.clear |=> (bestErr <= $past(bestErr)));
endmodule

// File: rtl/template_matcher.sv
module template_matcher
  import tmatch_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int VEC_LEN    = 70,
  parameter int NUM_SHIFTS = 11,
  parameter int MAX_TPL    = 4096,
  localparam int IDX_W     = $clog2(VEC_LEN),
  localparam int SHIFT_W   = $clog2(NUM_SHIFTS),
  localparam int TPL_W     = $clog2(MAX_TPL),
  localparam int CNT_W     = $clog2(MAX_TPL + 1),
  localparam int TADDR_W   = $clog2(MAX_TPL * VEC_LEN),
  localparam int ACC_W     = 2 * (SAMPLE_W + 1) + $clog2(VEC_LEN)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [CNT_W-1:0]    tplCount,
  output logic                vecRdEn,
  output logic [IDX_W-1:0]    vecAddr,
  input  logic [SAMPLE_W-1:0] vecRdData,
  output logic                tplRdEn,
  output logic [TADDR_W-1:0]  tplAddr,
  input  logic [SAMPLE_W-1:0] tplRdData,
  output logic                done,
  output logic [TPL_W-1:0]    bestTpl,
  output logic [SHIFT_W-1:0]  bestShift,
  output logic [ACC_W-1:0]    bestErr
);
  strobe_t            stb;
  logic               busy;
  logic [TPL_W-1:0]   curTpl;
  logic [SHIFT_W-1:0] curShift;

  tmatch_ctrl #(
    .VEC_LEN(VEC_LEN), .NUM_SHIFTS(NUM_SHIFTS), .MAX_TPL(MAX_TPL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .tplCount(tplCount),
    .vecRdEn(vecRdEn), .vecAddr(vecAddr), .tplRdEn(tplRdEn), .tplAddr(tplAddr),
    .done(done), .busy(busy), .stb(stb), .curTpl(curTpl), .curShift(curShift)
  );

  tmatch_dp #(
    .SAMPLE_W(SAMPLE_W), .VEC_LEN(VEC_LEN), .NUM_SHIFTS(NUM_SHIFTS), .MAX_TPL(MAX_TPL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .curTpl(curTpl), .curShift(curShift),
    .vecRdData(vecRdData), .tplRdData(tplRdData),
    .bestTpl(bestTpl), .bestShift(bestShift), .bestErr(bestErr)
  );

  // R6: while idle with no start, the reported result holds
  p_hold_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(bestErr) && $stable(bestTpl) && $stable(bestShift));
endmodule

// File: tb/template_matcher_tb.sv
`timescale 1ns/100ps
module template_matcher_tb;
  localparam int VLEN   = 70;
  localparam int NSH    = 11;
  localparam int TB_TPL = 8;
  localparam int PER    = 770;
  localparam longint ALL_ONES = (64'sd1 <<< 41) - 1;

  // scenario table: seed, template count, planted template, planted shift
  localparam int SCEN[5][4] = '{
    '{11, 4, 2, 7},
    '{23, 8, 0, 0},
    '{37, 5, 4, 10},
    '{41, 1, 0, 5},
    '{59, 6, 3, 2}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [12:0] tplCount = '0;
  logic vecRdEn, tplRdEn, done;
  logic [6:0]  vecAddr;
  logic [18:0] tplAddr;
  logic [15:0] vecRdData = '0, tplRdData = '0;
  logic [11:0] bestTpl;
  logic [3:0]  bestShift;
  logic [40:0] bestErr;

  logic signed [15:0] vecMem [VLEN];
  logic signed [15:0] tplMem [TB_TPL*VLEN];
  int checks = 0, failures = 0, badReads = 0;
  int curCount = 0;
  logic [31:0] rng;

  always #2.5 clk = ~clk;

  template_matcher u_dut (
    .clk(clk), .rstN(rstN), .start(start), .tplCount(tplCount),
    .vecRdEn(vecRdEn), .vecAddr(vecAddr), .vecRdData(vecRdData),
    .tplRdEn(tplRdEn), .tplAddr(tplAddr), .tplRdData(tplRdData),
    .done(done), .bestTpl(bestTpl), .bestShift(bestShift), .bestErr(bestErr)
  );

  // memories with one cycle of read latency; poison when not enabled
  always @(posedge clk) begin
    if (vecRdEn) vecRdData <= vecMem[vecAddr];
    if (tplRdEn) tplRdData <= (int'(tplAddr) < TB_TPL*VLEN) ? tplMem[tplAddr] : 16'h7FFF;
    else         tplRdData <= 16'h7ABC;
    if (tplRdEn && int'(tplAddr) >= curCount*VLEN) badReads++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [15:0] nextRand();
    rng = rng * 32'd1103515245 + 32'd12345;
    return rng[30:15];
  endfunction

  function automatic void fillScen(int seed, int n, int pt, int ps);
    rng = 32'(seed);
    for (int i = 0; i < VLEN; i++) vecMem[i] = nextRand();
    for (int k = 0; k < TB_TPL*VLEN; k++) tplMem[k] = nextRand();
    for (int j = 0; j < VLEN; j++) begin
      int i = j + ps - 5;
      if (i >= 0 && i < VLEN) tplMem[pt*VLEN + j] = vecMem[i] + 16'(signed'(nextRand() >>> 12));
    end
  endfunction

  // nested-loop reference: template outer, shift inner, strict minimum
  function automatic void model(int n, output int bt, output int bs, output longint be);
    be = ALL_ONES; bt = 0; bs = 0;
    for (int t = 0; t < n; t++)
      for (int s = 0; s < NSH; s++) begin
        longint e = 0;
        for (int i = 0; i < VLEN; i++) begin
          int j = i + 5 - s;
          longint tv = (j >= 0 && j < VLEN) ? longint'(tplMem[t*VLEN + j]) : 0;
          longint d = longint'(vecMem[i]) - tv;
          e += d * d;
        end
        if (e < be) begin be = e; bt = t; bs = s; end
      end
  endfunction

  // run one search; optionally issue a second start mid-run
  task automatic runSearch(input int n, input bit midStart, input string tag);
    int cyc = 0, et, es;
    longint ee;
    model(n, et, es, ee);
    curCount = n;
    @(negedge clk); start = 1'b1; tplCount = 13'(n);
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    while (!done && cyc < 20000) begin
      cyc++;
      if (midStart && cyc == 100) begin start = 1'b1; tplCount = 13'd1; end
      if (midStart && cyc == 101) begin start = 1'b0; tplCount = 13'(n); end
      @(negedge clk);
    end
    chk(cyc == n*PER + 2, {tag, " R5 done latency"}, cyc, n*PER + 2);
    chk(int'(bestTpl) == et, {tag, " R3 best template"}, bestTpl, et);
    chk(int'(bestShift) == es, {tag, " R2 best shift"}, bestShift, es);
    chk(longint'(bestErr) == ee, {tag, " R1 minimum error"}, bestErr, ee);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R5 done one cycle"}, done, 0);
  endtask

  initial begin
    #(150000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [40:0] holdErr;
    logic [11:0] holdTpl;
    logic [3:0]  holdSh;
    for (int i = 0; i < VLEN; i++) vecMem[i] = '0;
    for (int k = 0; k < TB_TPL*VLEN; k++) tplMem[k] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(done == 1'b0, "R10 done low", done, 0);
    chk(longint'(bestErr) == ALL_ONES, "R10 error all ones", bestErr, ALL_ONES);
    chk(bestTpl == '0 && bestShift == '0, "R10 index and shift zero", {bestTpl, bestShift}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // table-driven planted-match searches (R1, R2, R3, R5, R9)
    for (int s = 0; s < 5; s++) begin
      fillScen(SCEN[s][0], SCEN[s][1], SCEN[s][2], SCEN[s][3]);
      runSearch(SCEN[s][1], 1'b0, $sformatf("scen%0d", s));
      chk(int'(bestTpl) == SCEN[s][2] && int'(bestShift) == SCEN[s][3],
          "R3 planted pair found", {bestTpl, bestShift}, {SCEN[s][2][11:0], SCEN[s][3][3:0]});
    end

    // R3: all-zero data, every error equal, earliest pair wins
    for (int i = 0; i < VLEN; i++) vecMem[i] = '0;
    for (int k = 0; k < TB_TPL*VLEN; k++) tplMem[k] = '0;
    runSearch(3, 1'b0, "ties");
    chk(bestTpl == '0 && bestShift == '0 && bestErr == '0, "R3 tie keeps first pair",
        bestErr, 0);

    // R1: full-scale opposite signs, error above 32 bits
    for (int i = 0; i < VLEN; i++) vecMem[i] = 16'sh7FFF;
    for (int k = 0; k < TB_TPL*VLEN; k++) tplMem[k] = 16'sh8000;
    runSearch(2, 1'b0, "fullscale");
    chk(longint'(bestErr) == 65*longint'(65535)*65535 + 5*longint'(32767)*32767,
        "R1 wide accumulation", bestErr, 65*longint'(65535)*65535 + 5*longint'(32767)*32767);

    // R6: result holds after done while memory contents change
    holdErr = bestErr; holdTpl = bestTpl; holdSh = bestShift;
    for (int i = 0; i < VLEN; i++) vecMem[i] = 16'sd3;
    repeat (30) @(negedge clk);
    chk(bestErr == holdErr && bestTpl == holdTpl && bestShift == holdSh,
        "R6 outputs hold after done", bestErr, holdErr);

    // R8: zero templates
    runSearch(0, 1'b0, "zero");
    chk(longint'(bestErr) == ALL_ONES, "R8 zero count error all ones", bestErr, ALL_ONES);

    // R4: a new start clears a previous small minimum (zero count shows the cleared value)
    fillScen(71, 3, 1, 9);
    runSearch(3, 1'b1, "busystart R7");
    chk(int'(bestTpl) == 1 && int'(bestShift) == 9, "R7 mid-run start ignored",
        {bestTpl, bestShift}, {12'd1, 4'd9});
    runSearch(0, 1'b0, "clear");
    chk(longint'(bestErr) == ALL_ONES && bestTpl == '0, "R4 start clears minimum",
        bestErr, ALL_ONES);

    // R9: no template read outside the enabled range
    chk(badReads == 0, "R9 template reads within count", badReads, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule